// File: doc/BRIEF.md
# Sleep Entry and Wake Restore Sequencer

This block walks a clock and power controller through a fixed teardown into an ultra-low-power sleep state, and later walks it back up through a different restore order. Each step is sent as a one-cycle command carrying a step code and argument fields. The block then waits for the controller to acknowledge that same code before it moves on. A per-step watchdog stops the sequence and flags an error if the acknowledge never comes.

While the teardown runs, the block arms a set of wake sources: masked GPIO lines, a real-time-clock alarm, a timer alarm and a USB resume. The first qualifying event is latched together with the identity of its source. That event ends the sleep. If it arrives after arming but before sleep is reached, the block skips the sleep state and goes straight into the restore order.

Top module: `lp_seq_top`

## Requirements
- R1: After a `sleep_go` pulse from the active state, the first three commands are memory self-refresh entry (code 0), clear wake events (code 1) and arm wake sources (code 2), in that order.
- R2: The next commands are USB port suspend (code 3) and peripheral clock gate-off (code 4). Then come clock-set commands (code 5, source field 0 = main clock, divider field 1) for clock index 0 first and then indices 1, 2, 3 and 4.
- R3: Entry ends with PLLs off (code 6), RC on (code 7), main-clock select (code 8, source 1 = RC) and crystal off (code 9). After that last acknowledge, `sleep_req` is high and `seq_state` is 2 (asleep) until a wake is latched.
- R4: Restore starts with crystal on (code 10), main-clock select (code 8, source 0 = crystal), clock-set index 0 to source 0 divider 1, PLL start (code 11, clock field 0 = CPU PLL), and clock-set index 0 to source 1 (CPU PLL) divider 3.
- R5: Restore continues with PLL start clock field 1 (system PLL), clock-set index 1 to source 2 (system PLL) divider 2, clock-set index 4 to source 2 divider 1, PLL start clock field 2 (memory PLL), and self-refresh exit (code 12). It then returns `seq_state` to 0 (active).
- R6: Each command is valid for one cycle per step. The sequence advances only on `cmd_done` with `cmd_done_code` equal to the pending step code; an acknowledge with another code is ignored.
- R7: A GPIO line wakes only when its `gpio_mask` bit is 1. The RTC alarm, timer alarm and USB resume wake only when `wake_en` bit 0, 1 or 2 respectively is 1. Events before the arm step is acknowledged are discarded.
- R8: A qualifying wake latched during entry, after arming, makes the block skip sleep: `sleep_req` never rises and the restore commands follow the crystal-off step directly.
- R9: If no matching acknowledge arrives within `TIMEOUT_CYC` cycles of a command, `seq_err` rises and no further command is issued until reset.
- R10: `seq_state` is 1 during entry and 3 during restore. `wake_src` is 0 GPIO, 1 RTC, 2 timer or 3 USB; when sources fire in the same cycle, the lowest code wins.
- R11: After reset: no command, `sleep_req` low, `seq_state` 0, `seq_err` low, `wake_hit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_go | input | 1 | Request to start the entry sequence |
| cmd_done | input | 1 | Step acknowledge from the controller |
| cmd_done_code | input | 4 | Step code being acknowledged |
| gpio_wake | input | N_GPIO | GPIO wake lines |
| gpio_mask | input | N_GPIO | Per-line GPIO wake enable |
| rtc_alarm | input | 1 | RTC alarm event |
| tmr_alarm | input | 1 | Timer alarm event |
| usb_resume | input | 1 | USB resume event |
| wake_en | input | 3 | Enables for RTC, timer, USB wake |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 4 | Step code |
| cmd_clk | output | 3 | Clock index or PLL id |
| cmd_src | output | 2 | Source select |
| cmd_div | output | 3 | Divider value |
| sleep_req | output | 1 | Low-power mode request |
| seq_state | output | 2 | 0 active, 1 entering, 2 asleep, 3 exiting |
| seq_err | output | 1 | Step timeout flag |
| wake_hit | output | 1 | A wake event has been latched |
| wake_src | output | 2 | Source of the latched wake |

## Verification
The bench first targets ordering. A sequencer that swapped the primary and secondary clock switches, or reused the teardown order on restore, would produce commands that do not match the expected queue. It fires wake events before arming, on masked lines and through disabled sources. A design that latched these would leave sleep early or never reach it. A wake during entry must bypass sleep; a design that ignored it would raise `sleep_req` and hang there. A wrong-code acknowledge must stall the step and end in the timeout error, not advance the sequence.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int CODE_W = 4;

  localparam logic [3:0] ST_SR_ENTER = 4'd0;
  localparam logic [3:0] ST_WK_CLR   = 4'd1;
  localparam logic [3:0] ST_WK_ARM   = 4'd2;
  localparam logic [3:0] ST_USB_SUSP = 4'd3;
  localparam logic [3:0] ST_GCLK_OFF = 4'd4;
  localparam logic [3:0] ST_CLK_SET  = 4'd5;
  localparam logic [3:0] ST_PLL_OFF  = 4'd6;
  localparam logic [3:0] ST_RC_ON    = 4'd7;
  localparam logic [3:0] ST_MAIN_SEL = 4'd8;
  localparam logic [3:0] ST_XTAL_OFF = 4'd9;
  localparam logic [3:0] ST_XTAL_ON  = 4'd10;
  localparam logic [3:0] ST_PLL_ON   = 4'd11;
  localparam logic [3:0] ST_SR_EXIT  = 4'd12;

  localparam int ENTRY_STEPS = 14;
  localparam int EXIT_STEPS  = 10;
  localparam int IDX_W       = 5;

  typedef struct packed {
    logic [3:0] code;
    logic [2:0] clk;
    logic [1:0] src;
    logic [2:0] div;
  } step_t;

  typedef enum logic [1:0] {
    SEQ_ACTIVE   = 2'd0,
    SEQ_ENTERING = 2'd1,
    SEQ_ASLEEP   = 2'd2,
    SEQ_EXITING  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_SLEEP = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;
endpackage

// File: rtl/lp_step_rom.sv
module lp_step_rom
  import lp_seq_pkg::*;
(
  input  logic             restore,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  always_comb begin
    step = '0;
    if (!restore) begin
      case (idx)
        5'd0:  step.code = ST_SR_ENTER;
        5'd1:  step.code = ST_WK_CLR;
        5'd2:  step.code = ST_WK_ARM;
        5'd3:  step.code = ST_USB_SUSP;
        5'd4:  step.code = ST_GCLK_OFF;
        5'd5, 5'd6, 5'd7, 5'd8, 5'd9: begin
          step.code = ST_CLK_SET;
          step.clk  = 3'(idx - 5'd5);
          step.src  = 2'd0;
          step.div  = 3'd1;
        end
        5'd10: step.code = ST_PLL_OFF;
        5'd11: step.code = ST_RC_ON;
        5'd12: begin
          step.code = ST_MAIN_SEL;
          step.src  = 2'd1;
        end
        5'd13: step.code = ST_XTAL_OFF;
        default: step = '0;
      endcase
    end else begin
      case (idx)
        5'd0: step.code = ST_XTAL_ON;
        5'd1: begin
          step.code = ST_MAIN_SEL;
          step.src  = 2'd0;
        end
        5'd2: step = '{code: ST_CLK_SET, clk: 3'd0, src: 2'd0, div: 3'd1};
        5'd3: step = '{code: ST_PLL_ON,  clk: 3'd0, src: 2'd0, div: 3'd0};
        5'd4: step = '{code: ST_CLK_SET, clk: 3'd0, src: 2'd1, div: 3'd3};
        5'd5: step = '{code: ST_PLL_ON,  clk: 3'd1, src: 2'd0, div: 3'd0};
        5'd6: step = '{code: ST_CLK_SET, clk: 3'd1, src: 2'd2, div: 3'd2};
        5'd7: step = '{code: ST_CLK_SET, clk: 3'd4, src: 2'd2, div: 3'd1};
        5'd8: step = '{code: ST_PLL_ON,  clk: 3'd2, src: 2'd0, div: 3'd0};
        5'd9: step.code = ST_SR_EXIT;
        default: step = '0;
      endcase
    end
  end
endmodule

// File: rtl/lp_step_timer.sv
module lp_step_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run) begin
      if (cnt == LAST) expired <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R9
  expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && run && !clr) |=> expired);
endmodule

// File: rtl/lp_wake_unit.sv
module lp_wake_unit #(
  parameter int N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              arm,
  input  logic              disarm,
  input  logic [N_GPIO-1:0] gpio_wake,
  input  logic [N_GPIO-1:0] gpio_mask,
  input  logic              rtc_alarm,
  input  logic              tmr_alarm,
  input  logic              usb_resume,
  input  logic [2:0]        wake_en,
  output logic              pending,
  output logic [1:0]        src_id
);
  localparam int N_SRC = 4;

  logic             armed;
  logic [N_SRC-1:0] hit;
  logic [1:0]       first;

  assign hit[0] = |(gpio_wake & gpio_mask);
  assign hit[1] = rtc_alarm  & wake_en[0];
  assign hit[2] = tmr_alarm  & wake_en[1];
  assign hit[3] = usb_resume & wake_en[2];

  always_comb begin
    first = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hit[i]) first = 2'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      pending <= 1'b0;
      src_id  <= '0;
    end else if (clr) begin
      armed   <= 1'b0;
      pending <= 1'b0;
      src_id  <= '0;
    end else begin
      if (arm)         armed <= 1'b1;
      else if (disarm) armed <= 1'b0;
      if (armed && !pending && (|hit)) begin
        pending <= 1'b1;
        src_id  <= first;
      end
    end
  end

  // R7
  no_latch_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !pending) |=> !pending);

  // R10
  src_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !clr) |=> $stable(src_id));
endmodule

// File: rtl/lp_seq_top.sv
module lp_seq_top
  import lp_seq_pkg::*;
#(
  parameter int N_GPIO      = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_go,
  input  logic              cmd_done,
  input  logic [3:0]        cmd_done_code,
  input  logic [N_GPIO-1:0] gpio_wake,
  input  logic [N_GPIO-1:0] gpio_mask,
  input  logic              rtc_alarm,
  input  logic              tmr_alarm,
  input  logic              usb_resume,
  input  logic [2:0]        wake_en,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [2:0]        cmd_clk,
  output logic [1:0]        cmd_src,
  output logic [2:0]        cmd_div,
  output logic              sleep_req,
  output logic [1:0]        seq_state,
  output logic              seq_err,
  output logic              wake_hit,
  output logic [1:0]        wake_src
);
  localparam logic [IDX_W-1:0] ENTRY_LAST = IDX_W'(ENTRY_STEPS - 1);
  localparam logic [IDX_W-1:0] EXIT_LAST  = IDX_W'(EXIT_STEPS - 1);

  phase_e           phase;
  logic             restore;
  logic [IDX_W-1:0] idx;
  logic [3:0]       cur_code;

  logic             issue, go_sleep, go_active;
  logic             nxt_restore;
  logic [IDX_W-1:0] nxt_idx;
  logic             done_ok;
  logic             expired;
  logic             wk_pending;
  logic [1:0]       wk_src;
  step_t            nxt_step;

  assign done_ok = (phase == PH_WAIT) && cmd_done && (cmd_done_code == cur_code);

  always_comb begin
    issue       = 1'b0;
    go_sleep    = 1'b0;
    go_active   = 1'b0;
    nxt_restore = restore;
    nxt_idx     = idx;
    case (phase)
      PH_IDLE: if (sleep_go) begin
        issue       = 1'b1;
        nxt_restore = 1'b0;
        nxt_idx     = '0;
      end
      PH_WAIT: if (done_ok) begin
        if (!restore && idx == ENTRY_LAST) begin
          if (wk_pending) begin
            issue       = 1'b1;
            nxt_restore = 1'b1;
            nxt_idx     = '0;
          end else begin
            go_sleep = 1'b1;
          end
        end else if (restore && idx == EXIT_LAST) begin
          go_active = 1'b1;
        end else begin
          issue   = 1'b1;
          nxt_idx = idx + 1'b1;
        end
      end
      PH_SLEEP: if (wk_pending) begin
        issue       = 1'b1;
        nxt_restore = 1'b1;
        nxt_idx     = '0;
      end
      default: ;
    endcase
  end

  lp_step_rom u_rom (
    .restore (nxt_restore),
    .idx     (nxt_idx),
    .step    (nxt_step)
  );

  lp_step_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (issue),
    .run     (phase == PH_WAIT),
    .expired (expired)
  );

  lp_wake_unit #(.N_GPIO(N_GPIO)) u_wake (
    .clk        (clk),
    .rst        (rst),
    .clr        (done_ok && cur_code == ST_WK_CLR),
    .arm        (done_ok && cur_code == ST_WK_ARM),
    .disarm     (issue && nxt_restore),
    .gpio_wake  (gpio_wake),
    .gpio_mask  (gpio_mask),
    .rtc_alarm  (rtc_alarm),
    .tmr_alarm  (tmr_alarm),
    .usb_resume (usb_resume),
    .wake_en    (wake_en),
    .pending    (wk_pending),
    .src_id     (wk_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      restore   <= 1'b0;
      idx       <= '0;
      cur_code  <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_clk   <= '0;
      cmd_src   <= '0;
      cmd_div   <= '0;
      sleep_req <= 1'b0;
      seq_state <= SEQ_ACTIVE;
      seq_err   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (issue) begin
        phase     <= PH_WAIT;
        restore   <= nxt_restore;
        idx       <= nxt_idx;
        cur_code  <= nxt_step.code;
        cmd_valid <= 1'b1;
        cmd_code  <= nxt_step.code;
        cmd_clk   <= nxt_step.clk;
        cmd_src   <= nxt_step.src;
        cmd_div   <= nxt_step.div;
        sleep_req <= 1'b0;
        seq_state <= nxt_restore ? SEQ_EXITING : SEQ_ENTERING;
      end else if (go_sleep) begin
        phase     <= PH_SLEEP;
        sleep_req <= 1'b1;
        seq_state <= SEQ_ASLEEP;
      end else if (go_active) begin
        phase     <= PH_IDLE;
        seq_state <= SEQ_ACTIVE;
      end else if (phase == PH_WAIT && expired) begin
        phase   <= PH_HALT;
        seq_err <= 1'b1;
      end
    end
  end

  assign wake_hit = wk_pending;
  assign wake_src = wk_src;

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> (!cmd_valid && seq_err));

  // R3
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_req |-> (!cmd_valid && seq_state == SEQ_ASLEEP));

  // R6
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !cmd_done && !expired) |=> ($stable(idx) && !cmd_valid));

  // R8
  skip_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && wk_pending && !restore) |=> !sleep_req);
endmodule

// File: tb/lp_seq_top_tb.sv
module lp_seq_top_tb;
  localparam int NG = 8;
  localparam int TO = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_go = 1'b0;
  logic cmd_done = 1'b0;
  logic [3:0] cmd_done_code = '0;
  logic [NG-1:0] gpio_wake = '0, gpio_mask = '0;
  logic rtc_alarm = 1'b0, tmr_alarm = 1'b0, usb_resume = 1'b0;
  logic [2:0] wake_en = '0;
  logic cmd_valid, sleep_req, seq_err, wake_hit;
  logic [3:0] cmd_code;
  logic [2:0] cmd_clk, cmd_div;
  logic [1:0] cmd_src, seq_state, wake_src;

  always #5 clk = ~clk;

  lp_seq_top #(.N_GPIO(NG), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .sleep_go(sleep_go), .cmd_done(cmd_done),
    .cmd_done_code(cmd_done_code), .gpio_wake(gpio_wake), .gpio_mask(gpio_mask),
    .rtc_alarm(rtc_alarm), .tmr_alarm(tmr_alarm), .usb_resume(usb_resume),
    .wake_en(wake_en), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_clk(cmd_clk), .cmd_src(cmd_src), .cmd_div(cmd_div),
    .sleep_req(sleep_req), .seq_state(seq_state), .seq_err(seq_err),
    .wake_hit(wake_hit), .wake_src(wake_src));

  typedef struct {int code; int ck; int src; int div; int st; string req;} cmd_t;
  cmd_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int rsp_mode = 0;     // 0 echo code, 1 wrong code, 2 silent
  int rsp_lat = 0;
  int rsp_cnt = 0;
  bit rsp_busy = 0;
  logic [3:0] rsp_code = '0;
  bit sleep_seen = 0;
  int n_cmds = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void push(int c, int k, int s, int d, int st, string r);
    cmd_t e;
    e.code = c; e.ck = k; e.src = s; e.div = d; e.st = st; e.req = r;
    exp_q.push_back(e);
  endfunction

  function automatic void push_entry();
    push(0, 0, 0, 0, 1, "R1"); push(1, 0, 0, 0, 1, "R1"); push(2, 0, 0, 0, 1, "R1");
    push(3, 0, 0, 0, 1, "R2"); push(4, 0, 0, 0, 1, "R2");
    for (int k = 0; k < 5; k++) push(5, k, 0, 1, 1, "R2");
    push(6, 0, 0, 0, 1, "R3"); push(7, 0, 0, 0, 1, "R3");
    push(8, 0, 1, 0, 1, "R3"); push(9, 0, 0, 0, 1, "R3");
  endfunction

  function automatic void push_exit();
    push(10, 0, 0, 0, 3, "R4"); push(8, 0, 0, 0, 3, "R4");
    push(5, 0, 0, 1, 3, "R4"); push(11, 0, 0, 0, 3, "R4");
    push(5, 0, 1, 3, 3, "R4");
    push(11, 1, 0, 0, 3, "R5"); push(5, 1, 2, 2, 3, "R5");
    push(5, 4, 2, 1, 3, "R5"); push(11, 2, 0, 0, 3, "R5");
    push(12, 0, 0, 0, 3, "R5");
  endfunction

  // reference comparison and responder, every clock at the falling edge
  always @(negedge clk) begin
    cmd_done <= 1'b0;
    if (!rst) begin
      if (sleep_req) sleep_seen = 1;
      if (cmd_valid) begin
        n_cmds++;
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected command", int'(cmd_code), -1);
        end else begin
          cmd_t e;
          e = exp_q.pop_front();
          chk(int'(cmd_code) == e.code && int'(cmd_clk) == e.ck &&
              int'(cmd_src) == e.src && int'(cmd_div) == e.div,
              e.req, {cmd_code, 1'b0, cmd_clk, cmd_src, cmd_div},
              (e.code << 9) | (e.ck << 5) | (e.src << 3) | e.div);
          chk(int'(seq_state) == e.st, "R10 state", int'(seq_state), e.st);
        end
        rsp_busy = 1; rsp_cnt = rsp_lat; rsp_code = cmd_code;
      end
      if (rsp_busy && rsp_mode != 2) begin
        if (rsp_cnt == 0) begin
          cmd_done      <= 1'b1;
          cmd_done_code <= (rsp_mode == 1) ? rsp_code + 4'd1 : rsp_code;
          rsp_busy = 0;
        end else rsp_cnt--;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_q_empty();
    while (exp_q.size() != 0) @(negedge clk);
    cyc(4);
  endtask

  task automatic start_sleep();
    @(posedge clk); #1 sleep_go = 1'b1;
    @(posedge clk); #1 sleep_go = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; rsp_busy = 0; exp_q.delete();
    cyc(3); @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  initial begin
    do_reset();
    cyc(2);
    // R11 reset state
    chk(!cmd_valid && !sleep_req && seq_state == 0 && !seq_err && !wake_hit, "R11",
        {cmd_valid, sleep_req, seq_state, seq_err, wake_hit}, 0);

    // full cycle, immediate acks, GPIO wake
    rsp_mode = 0; rsp_lat = 0; gpio_mask = 8'h10; wake_en = 3'b000;
    push_entry();
    start_sleep();
    while (!sleep_req) @(negedge clk);
    cyc(5);
    chk(exp_q.size() == 0, "R3 entry count", exp_q.size(), 0);
    chk(sleep_req && seq_state == 2, "R3 asleep", int'(seq_state), 2);
    // R7: masked GPIO line, disabled RTC: must stay asleep
    gpio_wake = 8'h01; cyc(3); gpio_wake = 8'h00;
    pulse(rtc_alarm); cyc(5);
    chk(sleep_req && !wake_hit && !cmd_valid, "R7 masked", int'(wake_hit), 0);
    push_exit();
    gpio_wake = 8'h10; cyc(2); gpio_wake = 8'h00;
    wait_q_empty();
    chk(seq_state == 0 && !sleep_req, "R5 active", int'(seq_state), 0);
    chk(wake_hit && wake_src == 0, "R10 gpio src", int'(wake_src), 0);

    // early event before arming is dropped; later RTC+timer together
    rsp_lat = 3; wake_en = 3'b011; gpio_mask = '0;
    push_entry();
    start_sleep();
    pulse(rtc_alarm);
    while (!sleep_req) @(negedge clk);
    cyc(6);
    chk(sleep_req && !wake_hit, "R7 pre-arm", int'(wake_hit), 0);
    push_exit();
    @(posedge clk); #1 rtc_alarm = 1'b1; tmr_alarm = 1'b1;
    @(posedge clk); #1 rtc_alarm = 1'b0; tmr_alarm = 1'b0;
    wait_q_empty();
    chk(wake_src == 1, "R10 priority", int'(wake_src), 1);
    chk(seq_state == 0, "R5 active", int'(seq_state), 0);

    // wake during entry: sleep skipped
    rsp_lat = 2; wake_en = 3'b010; sleep_seen = 0;
    push_entry(); push_exit();
    start_sleep();
    while (!(cmd_valid && cmd_code == 4'd5)) @(negedge clk);
    pulse(tmr_alarm);
    wait_q_empty();
    chk(!sleep_seen, "R8 no sleep", int'(sleep_seen), 0);
    chk(wake_src == 2 && seq_state == 0, "R8 src", int'(wake_src), 2);

    // USB wake via enable bit 2
    rsp_lat = 0; wake_en = 3'b100;
    push_entry();
    start_sleep();
    while (!sleep_req) @(negedge clk);
    push_exit();
    pulse(usb_resume);
    wait_q_empty();
    chk(wake_src == 3, "R7 usb", int'(wake_src), 3);

    // R6 wrong-code ack ignored, R9 timeout
    rsp_mode = 1; n_cmds = 0;
    push(0, 0, 0, 0, 1, "R1");
    start_sleep();
    cyc(TO / 2);
    chk(n_cmds == 1 && !seq_err, "R6 wrong code", n_cmds, 1);
    cyc(TO + 10);
    chk(seq_err == 1'b1, "R9 timeout", int'(seq_err), 1);
    chk(n_cmds == 1, "R9 halted", n_cmds, 1);

    // R9 silent controller after reset
    rsp_mode = 2; do_reset(); n_cmds = 0;
    push(0, 0, 0, 0, 1, "R1");
    start_sleep();
    cyc(TO + 10);
    chk(seq_err && n_cmds == 1, "R9 silent", n_cmds, 1);
    do_reset(); cyc(2);
    chk(!seq_err && seq_state == 0, "R11 re-reset", int'(seq_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule